// File: doc/BRIEF.md
# Suppressed Multi-Channel Energy Summer with Cross-Crate Trigger

This block forms a board-level energy sum from a set of digitizer channels and turns it into a trigger decision. On every clock (4 ns at the nominal rate) it takes one 12-bit, pedestal-corrected amplitude per channel. Each channel has its own low-energy threshold. A channel whose amplitude is under that threshold is replaced by zero, and any other channel goes through unchanged. A registered adder tree then reduces the channels to one 16-bit board sum on every cycle. That sum is sent on to a crate-level processor.

A second stage adds the board sum to a sum that arrives from another crate and carries its own valid flag. The result is an 18-bit global sum that saturates instead of wrapping. This stage compares the global sum with a programmable trigger level. When the sum rises above that level it emits a one-cycle trigger pulse, and a programmable hold-off then blocks any new trigger for a set number of cycles. All thresholds and the hold-off length are loaded through a plain register write port.

The data stream has no back-pressure. The block accepts a sample in every cycle that `in_valid_i` is high and never stalls. The consumer of `sum_o`/`gsum_o` must take a value in every cycle, because there is no ready input. The channel count must be a power of two.

Top module: `esum_trigger`

## Requirements
- R1: A channel whose amplitude is strictly less than its channel threshold adds zero to the board sum.
- R2: A channel whose amplitude is equal to or greater than its threshold adds its full amplitude to the board sum.
- R3: The board sum `sum_o` is the 16-bit total of the channels that pass, and `sum_valid_o` is high with it. Both appear after the fifth rising edge, counting the edge that captures the input. A new sum is produced on every cycle.
- R4: A cycle with `in_valid_i` low produces `sum_valid_o` low and `sum_o` equal to zero five edges later.
- R5: `gsum_o` is updated one edge after `sum_o`. It equals the board sum plus `rem_sum_i` when `rem_valid_i` is high. When `rem_valid_i` is low, the remote value has no effect.
- R6: When the addition overflows 18 bits, `gsum_o` holds at 262143 and does not wrap.
- R7: `trig_o` goes high for exactly one cycle, one edge after `gsum_o` rises from at or below the trigger level to strictly above it. It stays low while the sum remains above the level.
- R8: After a pulse, any new pulse is blocked for the hold-off count of N cycles. The next possible pulse comes N+1 cycles after the previous one. A crossing that falls inside that window is lost.
- R9: A configuration write takes effect on the next edge after the edge that stores it. Addresses 0 to 15 select the channel thresholds (data bits 11:0). Address 16 selects the 18-bit trigger level. Address 17 selects the hold-off count (data bits 7:0).
- R10: After reset all channel thresholds are 0, the trigger level is 262143 so that no trigger can fire, and the hold-off is 0. `sum_valid_o`, `sum_o`, `gsum_o` and `trig_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Channel sample vector is valid this cycle |
| in_data_i | input | 192 | 16 channels of 12 bits; channel c in bits 12c+11:12c |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration register select |
| cfg_data_i | input | 18 | Configuration write data |
| rem_valid_i | input | 1 | Remote crate sum is valid |
| rem_sum_i | input | 18 | Sum from the other crate |
| sum_valid_o | output | 1 | Board sum is valid |
| sum_o | output | 16 | Suppressed board energy sum |
| gsum_o | output | 18 | Saturated global sum |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
The hold-off window is the hardest condition to reach from the ports. A blocked retrigger only shows when the global sum drops and rises again while the counter is still running. The bench therefore toggles the remote-valid flag with a four-cycle period while the board sum stays at zero, so the global sum crosses the trigger level on every fourth cycle. It then measures the spacing of the pulses with two different hold-off lengths. Saturation is reached by feeding a remote sum close to the 18-bit maximum while every channel sits at full scale.

// File: rtl/esum_pkg.sv
package esum_pkg;
  parameter int NCH      = 16;
  parameter int CH_W     = 12;
  parameter int SUM_W    = 16;
  parameter int GSUM_W   = 18;
  parameter int HOLD_W   = 8;
  parameter int ADDR_W   = 5;
  parameter int ADDR_TRIG = 16;
  parameter int ADDR_HOLD = 17;
endpackage

// File: rtl/esum_suppress.sv
module esum_suppress #(
  parameter int NCH    = 16,
  parameter int CH_W   = 12,
  parameter int ADDR_W = 5,
  parameter int CFG_W  = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [NCH*CH_W-1:0]   in_data,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [CFG_W-1:0]      cfg_data,
  output logic                  out_valid,
  output logic [NCH*CH_W-1:0]   out_data
);
  logic [CH_W-1:0] thr_q [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) thr_q[c] <= '0;
    end else if (cfg_we) begin
      for (int c = 0; c < NCH; c++)
        if (cfg_addr == ADDR_W'(c)) thr_q[c] <= cfg_data[CH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      for (int c = 0; c < NCH; c++) begin
        if (in_valid && in_data[c*CH_W +: CH_W] >= thr_q[c])
          out_data[c*CH_W +: CH_W] <= in_data[c*CH_W +: CH_W];
        else
          out_data[c*CH_W +: CH_W] <= '0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chk
      assert_below_zeroed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[g*CH_W +: CH_W] < thr_q[g]) |=> (out_data[g*CH_W +: CH_W] == '0));
      assert_above_passed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data[g*CH_W +: CH_W] >= thr_q[g]) |=>
          (out_data[g*CH_W +: CH_W] == $past(in_data[g*CH_W +: CH_W])));
    end
  endgenerate
endmodule

// File: rtl/esum_tree.sv
module esum_tree #(
  parameter int NCH   = 16,
  parameter int CH_W  = 12,
  parameter int SUM_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [NCH*CH_W-1:0] in_data,
  output logic                out_valid,
  output logic [SUM_W-1:0]    out_sum
);
  localparam int LVLS = $clog2(NCH);

  logic [LVLS-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[LVLS-2:0], in_valid};
  end

  genvar l;
  generate
    for (l = 0; l <= LVLS; l++) begin : g_lvl
      logic [SUM_W-1:0] node [NCH>>l];
      if (l == 0) begin : g_leaf
        always_comb begin
          for (int n = 0; n < NCH; n++) node[n] = SUM_W'(in_data[n*CH_W +: CH_W]);
        end
      end else begin : g_add
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            for (int n = 0; n < (NCH>>l); n++) node[n] <= '0;
          end else begin
            for (int n = 0; n < (NCH>>l); n++)
              node[n] <= g_lvl[l-1].node[2*n] + g_lvl[l-1].node[2*n+1];
          end
        end
      end
    end
  endgenerate

  assign out_valid = vld_q[LVLS-1];
  assign out_sum   = g_lvl[LVLS].node[0];
endmodule

// File: rtl/esum_trig.sv
module esum_trig #(
  parameter int SUM_W     = 16,
  parameter int GSUM_W    = 18,
  parameter int HOLD_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int ADDR_TRIG = 16,
  parameter int ADDR_HOLD = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_valid,
  input  logic [SUM_W-1:0]  loc_sum,
  input  logic              rem_valid,
  input  logic [GSUM_W-1:0] rem_sum,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [GSUM_W-1:0] cfg_data,
  output logic [GSUM_W-1:0] gsum,
  output logic              trig
);
  logic [GSUM_W-1:0] thr_q;
  logic [HOLD_W-1:0] hold_len, hold_cnt;
  logic [GSUM_W:0]   wide;
  logic [GSUM_W-1:0] gsum_d;
  logic              above, above_q, fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q    <= '1;
      hold_len <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_W'(ADDR_TRIG)) thr_q    <= cfg_data;
      if (cfg_addr == ADDR_W'(ADDR_HOLD)) hold_len <= cfg_data[HOLD_W-1:0];
    end
  end

  always_comb begin
    wide   = (GSUM_W+1)'(loc_valid ? loc_sum : '0) + (GSUM_W+1)'(rem_valid ? rem_sum : '0);
    gsum_d = wide[GSUM_W] ? '1 : wide[GSUM_W-1:0];
    above  = gsum > thr_q;
    fire   = above && !above_q && (hold_cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gsum     <= '0;
      above_q  <= 1'b0;
      trig     <= 1'b0;
      hold_cnt <= '0;
    end else begin
      gsum    <= gsum_d;
      above_q <= above;
      trig    <= fire;
      if (fire)                 hold_cnt <= hold_len;
      else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rem_valid |=> (gsum >= $past(rem_sum)));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  assert_pulse_needs_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> ($past(gsum) > $past(thr_q)));
  assert_holdoff_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt != '0) |=> !trig);
endmodule

// File: rtl/esum_trigger.sv
module esum_trigger
  import esum_pkg::*;
#(
  parameter int P_NCH    = NCH,
  parameter int P_CH_W   = CH_W,
  parameter int P_SUM_W  = SUM_W,
  parameter int P_GSUM_W = GSUM_W,
  parameter int P_HOLD_W = HOLD_W,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid_i,
  input  logic [P_NCH*P_CH_W-1:0]  in_data_i,
  input  logic                     cfg_we_i,
  input  logic [P_ADDR_W-1:0]      cfg_addr_i,
  input  logic [P_GSUM_W-1:0]      cfg_data_i,
  input  logic                     rem_valid_i,
  input  logic [P_GSUM_W-1:0]      rem_sum_i,
  output logic                     sum_valid_o,
  output logic [P_SUM_W-1:0]       sum_o,
  output logic [P_GSUM_W-1:0]      gsum_o,
  output logic                     trig_o
);
  logic                    sup_valid;
  logic [P_NCH*P_CH_W-1:0] sup_data;

  esum_suppress #(.NCH(P_NCH), .CH_W(P_CH_W), .ADDR_W(P_ADDR_W), .CFG_W(P_GSUM_W)) u_sup (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid_i), .in_data(in_data_i),
    .cfg_we(cfg_we_i), .cfg_addr(cfg_addr_i), .cfg_data(cfg_data_i),
    .out_valid(sup_valid), .out_data(sup_data));

  esum_tree #(.NCH(P_NCH), .CH_W(P_CH_W), .SUM_W(P_SUM_W)) u_tree (
    .clk(clk), .rst_n(rst_n), .in_valid(sup_valid), .in_data(sup_data),
    .out_valid(sum_valid_o), .out_sum(sum_o));

  esum_trig #(.SUM_W(P_SUM_W), .GSUM_W(P_GSUM_W), .HOLD_W(P_HOLD_W), .ADDR_W(P_ADDR_W),
              .ADDR_TRIG(ADDR_TRIG), .ADDR_HOLD(ADDR_HOLD)) u_trig (
    .clk(clk), .rst_n(rst_n), .loc_valid(sum_valid_o), .loc_sum(sum_o),
    .rem_valid(rem_valid_i), .rem_sum(rem_sum_i),
    .cfg_we(cfg_we_i), .cfg_addr(cfg_addr_i), .cfg_data(cfg_data_i),
    .gsum(gsum_o), .trig(trig_o));

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid_o |-> $past(in_valid_i, 5));
  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_valid_o |-> (sum_o == '0));
endmodule

// File: tb/tb_esum_trigger.sv
`timescale 1ns/1ps
module tb_esum_trigger;
  localparam int NC = 16;
  localparam int CW = 12;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic [NC*CW-1:0]   in_data = '0;
  logic               cfg_we = 1'b0;
  logic [4:0]         cfg_addr = '0;
  logic [17:0]        cfg_data = '0;
  logic               rem_valid = 1'b0;
  logic [17:0]        rem_sum = '0;
  logic               sum_valid;
  logic [15:0]        sum;
  logic [17:0]        gsum;
  logic               trig;

  int checks = 0;
  int errors = 0;
  int chv [NC];
  int thr [NC];

  always #2 clk = ~clk;

  esum_trigger dut (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_data_i(cfg_data),
    .rem_valid_i(rem_valid), .rem_sum_i(rem_sum),
    .sum_valid_o(sum_valid), .sum_o(sum), .gsum_o(gsum), .trig_o(trig));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_chans();
    for (int c = 0; c < NC; c++) in_data[c*CW +: CW] = CW'(chv[c]);
  endtask

  function automatic int expect_sum();
    int s = 0;
    for (int c = 0; c < NC; c++) if (chv[c] >= thr[c]) s += chv[c];
    return s;
  endfunction

  task automatic cfg_write(input int addr, input int data);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_data = 18'(data);
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic set_thr(input int c, input int v);
    thr[c] = v;
    cfg_write(c, v);
  endtask

  task automatic t_reset();
    tick(1);
    check("R10 sum_valid in reset", sum_valid, 0);
    check("R10 gsum in reset", gsum, 0);
    rst_n = 1'b1;
    tick(2);
    check("R10 trig after reset", trig, 0);
    check("R10 sum after reset", sum, 0);
    rem_valid = 1'b1; rem_sum = 18'h3FFFF;
    tick(8);
    check("R10 gsum at max", gsum, 262143);
    check("R10 default trigger level blocks trig", trig, 0);
    rem_valid = 1'b0; rem_sum = '0;
    tick(3);
  endtask

  task automatic t_suppress();
    for (int c = 0; c < NC; c++) set_thr(c, 100*c + 50);
    for (int c = 0; c < NC; c++)
      chv[c] = (c % 3 == 0) ? thr[c] - 1 : (c % 3 == 1) ? thr[c] : 4095;
    apply_chans(); in_valid = 1'b1;
    tick(7);
    check("R1 R2 mixed below/equal/above", sum, expect_sum());
    for (int c = 0; c < NC; c++) chv[c] = thr[c] - 1;
    apply_chans();
    tick(7);
    check("R1 all below threshold", sum, 0);
    for (int c = 0; c < NC; c++) chv[c] = 4095;
    apply_chans();
    tick(7);
    check("R2 R3 all full scale", sum, 65520);
    for (int c = 0; c < NC; c++) set_thr(c, 0);
    in_valid = 1'b0;
    tick(7);
  endtask

  task automatic t_latency();
    for (int c = 0; c < NC; c++) chv[c] = 1;
    apply_chans(); in_valid = 1'b1;
    tick(1);
    for (int c = 0; c < NC; c++) chv[c] = 2;
    apply_chans();
    tick(1);
    for (int c = 0; c < NC; c++) chv[c] = 3;
    apply_chans();
    tick(1);
    in_valid = 1'b0;
    tick(1);
    check("R3 not valid after 4 edges", sum_valid, 0);
    tick(1);
    check("R3 valid after 5 edges", sum_valid, 1);
    check("R3 first sum", sum, 16);
    tick(1);
    check("R3 second sum back-to-back", sum, 32);
    check("R5 gsum one edge after sum", gsum, 16);
    tick(1);
    check("R3 third sum back-to-back", sum, 48);
    tick(1);
    check("R4 valid drops", sum_valid, 0);
    tick(3);
  endtask

  task automatic t_invalid();
    for (int c = 0; c < NC; c++) chv[c] = 4095;
    apply_chans(); in_valid = 1'b0;
    rem_valid = 1'b1; rem_sum = 18'd777;
    tick(8);
    check("R4 sum zero when input invalid", sum, 0);
    check("R4 sum_valid low", sum_valid, 0);
    check("R4 gsum is remote only", gsum, 777);
    rem_valid = 1'b0;
    tick(2);
  endtask

  task automatic t_remote();
    for (int c = 0; c < NC; c++) chv[c] = 10;
    apply_chans(); in_valid = 1'b1;
    rem_valid = 1'b1; rem_sum = 18'd1000;
    tick(8);
    check("R5 remote added", gsum, 1160);
    rem_valid = 1'b0; rem_sum = 18'd5000;
    tick(2);
    check("R5 invalid remote ignored", gsum, 160);
    for (int c = 0; c < NC; c++) chv[c] = 4095;
    apply_chans();
    rem_valid = 1'b1; rem_sum = 18'd100000;
    tick(8);
    check("R6 no saturation below max", gsum, 165520);
    rem_sum = 18'(262143 - 100);
    tick(2);
    check("R6 saturates at max", gsum, 262143);
    in_valid = 1'b0; rem_valid = 1'b0; rem_sum = '0;
    tick(8);
  endtask

  task automatic t_trigger();
    int pulses;
    cfg_write(16, 1000);
    rem_valid = 1'b1; rem_sum = 18'd500;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin tick(1); pulses += trig; end
    check("R7 no pulse below level", pulses, 0);
    rem_sum = 18'd1000;
    pulses = 0;
    for (int i = 0; i < 6; i++) begin tick(1); pulses += trig; end
    check("R7 no pulse at equal level", pulses, 0);
    rem_sum = 18'd500;
    tick(4);
    rem_sum = 18'd1500;
    tick(1);
    check("R7 no pulse one edge after input", trig, 0);
    tick(1);
    check("R7 pulse two edges after input", trig, 1);
    pulses = 1;
    for (int i = 0; i < 10; i++) begin tick(1); pulses += trig; end
    check("R7 single pulse while above", pulses, 1);
    rem_valid = 1'b0;
    tick(4);
  endtask

  task automatic run_toggle(input int hold, output int count, output int gap);
    int first, second;
    cfg_write(17, hold);
    rem_valid = 1'b0; rem_sum = 18'd1500;
    tick(20);
    count = 0; first = -1; second = -1;
    for (int i = 0; i < 40; i++) begin
      rem_valid = (i % 4) < 2;
      tick(1);
      if (trig) begin
        count++;
        if (first < 0) first = i; else if (second < 0) second = i;
      end
    end
    gap = second - first;
    rem_valid = 1'b0;
    tick(20);
  endtask

  task automatic t_holdoff();
    int n, gap;
    run_toggle(10, n, gap);
    check("R8 pulse spacing with hold-off 10", gap, 12);
    check("R8 pulse count with hold-off 10", n, 4);
    run_toggle(0, n, gap);
    check("R8 pulse spacing with no hold-off", gap, 4);
    check("R8 pulse count with no hold-off", n, 10);
  endtask

  task automatic t_cfg_timing();
    for (int c = 0; c < NC; c++) chv[c] = 100;
    apply_chans(); in_valid = 1'b1;
    tick(8);
    check("R9 baseline sum", sum, 1600);
    cfg_we = 1'b1; cfg_addr = 5'd0; cfg_data = 18'd200;
    tick(1);
    cfg_we = 1'b0;
    tick(4);
    check("R9 old threshold still used at write edge", sum, 1600);
    tick(1);
    check("R9 new threshold used on next edge", sum, 1500);
    in_valid = 1'b0;
    tick(6);
  endtask

  bit done = 0;

  initial begin
    for (int c = 0; c < NC; c++) begin thr[c] = 0; chv[c] = 0; end
    t_reset();
    t_latency();
    t_suppress();
    t_invalid();
    t_remote();
    t_trigger();
    t_holdoff();
    t_cfg_timing();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule